// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns two phase signals from an incremental encoder into a signed motion count. Both phases arrive already synchronized to the system clock. Each cycle the block compares them with the values it captured on the previous cycle. In quadrature mode, every edge on either phase moves the counter by one step, so one full input period gives four counts. The direction of each step follows from where the new state sits in the Gray-code cycle.

A two-bit source select sets how the counter is driven. It can run as a quadrature decoder, as a clock-plus-direction counter, or as a counter that only goes up or only goes down on the rising edges of the first phase. A swap control exchanges the two phases before decoding, which reverses the counting sense. If both phases change between two samples, the block does not count. Instead it sets a sticky error flag, which stays set until a clear strobe arrives. That flag can also drive an interrupt line, gated by an enable.

Top module: `quad_pos_counter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, count_o is 0, dir_o is 0, phase_err_o is 0 and irq_o is 0.
- R2: With mode_i = 2'b00 (quadrature), the decoder state is {A,B} with A as the high bit. A single-bit change along 00→01→11→10→00 adds one to count_o, and the opposite order subtracts one. Over one full cycle of the inputs this gives four steps.
- R3: dir_o becomes 1 on the cycle after an increment and 0 on the cycle after a decrement. It holds its value on cycles with no step.
- R4: In quadrature mode, two consecutive edges on the same phase reverse the direction. The second edge steps the counter back the way it came.
- R5: In quadrature mode, if A and B both change between two samples, count_o and dir_o do not change and phase_err_o becomes 1 on the following cycle.
- R6: phase_err_o stays 1 until err_clr_i is sampled high. If a new phase error arrives in the same cycle as the clear, the flag stays set.
- R7: irq_o equals phase_err_o AND irq_en_i.
- R8: When swap_i is 1, the A and B inputs are exchanged before decoding in every mode. In quadrature mode this turns each increment into a decrement and each decrement into an increment. Changing swap_i by itself produces no step and no error.
- R9: With mode_i = 2'b01 (direction-count), a rising edge of A adds one when B is 1 and subtracts one when B is 0, and dir_o takes the value of B. Falling edges of A and any edge of B do not count.
- R10: With mode_i = 2'b10, each rising edge of A adds one. With mode_i = 2'b11, each rising edge of A subtracts one. In both modes, B and the falling edges of A have no effect and no phase error is flagged.
- R11: count_o is 32 bits and wraps modulo 2^32. One decrement from 0 gives 32'hFFFF_FFFF, and one increment from there returns it to 0.
- R12: The previous-sample register follows the inputs during reset. An input level that is already present when reset is released causes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 1 | Phase A, synchronized |
| b_i | input | 1 | Phase B, synchronized |
| mode_i | input | 2 | Source select: 00 quadrature, 01 direction-count, 10 up, 11 down |
| swap_i | input | 1 | Exchange A and B before decoding |
| err_clr_i | input | 1 | Clear strobe for the phase-error flag |
| irq_en_i | input | 1 | Lets the phase-error flag drive irq_o |
| count_o | output | 32 | Position count |
| dir_o | output | 1 | Direction of the last step, 1 = up |
| phase_err_o | output | 1 | Sticky phase-error flag |
| irq_o | output | 1 | Phase-error interrupt |

## Verification
The bench checks the following corner cases, each against what a faulty design would do:

- **Bouncing on one phase.** A design that kept the direction from the previous edge, instead of using the Gray position, would keep counting forward.
- **Both phases changing together.** A design that counted this case would step by one or two. A design that failed to hold the flag would lose it after one cycle.
- **A clear that lands on a new error.** The flag must stay set.
- **Toggling swap while the phases are unequal.** A design that stored the swapped values as the previous sample would report a false error.
- **Decrement from zero.** This exposes a counter that saturates instead of wrapping.
- **Reset released with both inputs high.** This exposes a previous-sample register reset to zero, which would produce a spurious error or step.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD   = 2'b00,
    SRC_DIRCNT = 2'b01,
    SRC_UP     = 2'b10,
    SRC_DOWN   = 2'b11
  } src_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic err;
  } step_t;

  // position of a {A,B} state along the forward Gray cycle
  function automatic logic [1:0] gray_pos(input logic [1:0] s);
    return {s[1], s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/qdec_sampler.sv
module qdec_sampler (
  input  logic       clk_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       swap_i,
  output logic [1:0] cur_o,
  output logic [1:0] prev_o
);
  logic [1:0] raw_q;

  // no reset: tracks pins during reset so release causes no step
  always_ff @(posedge clk_i) raw_q <= {a_i, b_i};

  // swap applied to both samples so toggling swap_i is not an edge
  assign cur_o  = swap_i ? {b_i, a_i}       : {a_i, b_i};
  assign prev_o = swap_i ? {raw_q[0], raw_q[1]} : raw_q;
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic [1:0] cur_i,
  input  logic [1:0] prev_i,
  input  logic [1:0] mode_i,
  output step_t      step_o
);
  logic [1:0] delta;
  logic       rise_a;

  always_comb begin
    delta  = gray_pos(cur_i) - gray_pos(prev_i);
    rise_a = cur_i[1] & ~prev_i[1];
    step_o = '0;
    unique case (src_mode_e'(mode_i))
      SRC_QUAD: begin
        step_o.up  = (delta == 2'd1);
        step_o.dn  = (delta == 2'd3);
        step_o.err = (delta == 2'd2);
      end
      SRC_DIRCNT: begin
        step_o.up = rise_a &  cur_i[0];
        step_o.dn = rise_a & ~cur_i[0];
      end
      SRC_UP:   step_o.up = rise_a;
      SRC_DOWN: step_o.dn = rise_a;
      default:  step_o = '0;
    endcase
  end
endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      dir_o   <= 1'b0;
    end else if (up_i) begin
      count_o <= count_o + ONE;
      dir_o   <= 1'b1;
    end else if (dn_i) begin
      count_o <= count_o - ONE;
      dir_o   <= 1'b0;
    end
  end

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == $past(count_o)) || (count_o == $past(count_o) + ONE) ||
    (count_o == $past(count_o) - ONE));

  assert_dir_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_i |=> dir_o);

  assert_dir_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i) |=> !dir_o);
endmodule

// File: rtl/qdec_err_flag.sv
module qdec_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  assert_clear_works_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [1:0]       mode_i,
  input  logic             swap_i,
  input  logic             err_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             phase_err_o,
  output logic             irq_o
);
  import qdec_pkg::*;

  logic [1:0] cur, prev;
  step_t      step;

  qdec_sampler u_sampler (
    .clk_i  (clk_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .swap_i (swap_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  qdec_step_decode u_decode (
    .cur_i  (cur),
    .prev_i (prev),
    .mode_i (mode_i),
    .step_o (step)
  );

  qdec_pos_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .up_i    (step.up),
    .dn_i    (step.dn),
    .count_o (count_o),
    .dir_o   (dir_o)
  );

  qdec_err_flag u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (step.err),
    .clr_i  (err_clr_i),
    .flag_o (phase_err_o)
  );

  assign irq_o = phase_err_o & irq_en_i;

  assert_step_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step.up, step.dn, step.err}));

  assert_err_holds_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step.err |=> ($stable(count_o) && $stable(dir_o)));

  assert_err_only_quad_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00) |-> !step.err);
endmodule

// File: tb/quad_pos_counter_tb.sv
`timescale 1ns/1ps
module quad_pos_counter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a = 1'b0, b = 1'b0, sw = 1'b0, clr = 1'b0, en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] count;
  logic        dir, perr, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_cnt = '0;
  logic        m_dir = 1'b0, m_flag = 1'b0, m_pa = 1'b0, m_pb = 1'b0;

  always #2.5 clk = ~clk;

  quad_pos_counter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .mode_i(mode),
    .swap_i(sw), .err_clr_i(clr), .irq_en_i(en),
    .count_o(count), .dir_o(dir), .phase_err_o(perr), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(count == m_cnt, tag, count, m_cnt);
    chk(dir == m_dir, tag, 32'(dir), 32'(m_dir));
    chk(perr == m_flag, tag, 32'(perr), 32'(m_flag));
    chk(irq == (m_flag & en), "R7", 32'(irq), 32'(m_flag & en));
  endtask

  function automatic int gray_step(input logic [1:0] p, input logic [1:0] c);
    case ({p, c})
      4'b0001, 4'b0111, 4'b1110, 4'b1000: return 1;
      4'b0100, 4'b1101, 4'b1011, 4'b0010: return -1;
      default: return 0;
    endcase
  endfunction

  // drive at negedge, update model, sample at next negedge
  task automatic cyc(input logic na, input logic nb, input logic [1:0] md,
                     input logic nsw, input logic nclr, input logic nen, input string tag);
    logic qa, qb, pa, pb;
    int s;
    a = na; b = nb; mode = md; sw = nsw; clr = nclr; en = nen;
    qa = nsw ? nb : na;  qb = nsw ? na : nb;
    pa = nsw ? m_pb : m_pa; pb = nsw ? m_pa : m_pb;
    s = 0;
    if (md == 2'b00) begin
      s = gray_step({pa, pb}, {qa, qb});
      if (pa != qa && pb != qb) m_flag = 1'b1;
      else if (nclr) m_flag = 1'b0;
    end else begin
      if (!pa && qa) begin
        if (md == 2'b01) s = qb ? 1 : -1;
        else if (md == 2'b10) s = 1;
        else s = -1;
      end
      if (nclr) m_flag = 1'b0;
    end
    if (s == 1)  begin m_cnt = m_cnt + 1; m_dir = 1'b1; end
    if (s == -1) begin m_cnt = m_cnt - 1; m_dir = 1'b0; end
    m_pa = na; m_pb = nb;
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input logic ra, input logic rb);
    rst_ni = 1'b0; a = ra; b = rb; clr = 1'b0;
    m_cnt = '0; m_dir = 1'b0; m_flag = 1'b0; m_pa = ra; m_pb = rb;
    repeat (3) @(negedge clk);
    chk(count == 0 && dir == 0 && perr == 0 && irq == 0, "R1", count, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    en = 1'b1;
    do_reset(1'b1, 1'b1);
    // R12: level present at release is not an edge
    cyc(1, 1, 2'b00, 0, 0, 1, "R12");
    chk(count == 0 && perr == 0, "R12", count, 0);
    // R11: wrap below zero and back
    cyc(0, 1, 2'b00, 0, 0, 1, "R11");
    chk(count == 32'hFFFF_FFFF, "R11", count, 32'hFFFF_FFFF);
    cyc(1, 1, 2'b00, 0, 0, 1, "R11");
    chk(count == 0, "R11", count, 0);
    // R2: full forward cycle from 11: 11->10->00->01->11
    cyc(1, 0, 2'b00, 0, 0, 1, "R2");
    cyc(0, 0, 2'b00, 0, 0, 1, "R2");
    cyc(0, 1, 2'b00, 0, 0, 1, "R2");
    cyc(1, 1, 2'b00, 0, 0, 1, "R2");
    chk(count == 4 && dir == 1, "R2", count, 4);
    cyc(1, 1, 2'b00, 0, 0, 1, "R3");
    chk(dir == 1, "R3", 32'(dir), 1);
    // R4: bounce on A: 11->01 (down), 01->11 (up)
    cyc(0, 1, 2'b00, 0, 0, 1, "R4");
    chk(count == 3 && dir == 0, "R4", count, 3);
    cyc(1, 1, 2'b00, 0, 0, 1, "R4");
    chk(count == 4 && dir == 1, "R4", count, 4);
    // R5: both change
    cyc(0, 0, 2'b00, 0, 0, 0, "R5");
    chk(count == 4 && perr == 1 && irq == 0, "R5", count, 4);
    cyc(0, 0, 2'b00, 0, 0, 1, "R7");
    chk(irq == 1, "R7", 32'(irq), 1);
    cyc(0, 0, 2'b00, 0, 0, 1, "R6");
    chk(perr == 1, "R6", 32'(perr), 1);
    // R6: clear coincident with new error keeps flag
    cyc(1, 1, 2'b00, 0, 1, 1, "R6");
    chk(perr == 1, "R6", 32'(perr), 1);
    cyc(1, 1, 2'b00, 0, 1, 1, "R6");
    chk(perr == 0, "R6", 32'(perr), 0);
    // R8: swap toggle alone with A!=B, then reversed counting
    cyc(1, 0, 2'b00, 0, 0, 1, "R8");
    chk(count == 5, "R8", count, 5);
    cyc(1, 0, 2'b00, 1, 0, 1, "R8");
    chk(count == 5 && perr == 0, "R8", count, 5);
    cyc(0, 0, 2'b00, 1, 0, 1, "R8");
    chk(count == 4 && dir == 0, "R8", count, 4);
    // R9: direction-count
    cyc(0, 1, 2'b01, 0, 0, 1, "R9");
    cyc(1, 1, 2'b01, 0, 0, 1, "R9");
    chk(count == 5 && dir == 1, "R9", count, 5);
    cyc(0, 0, 2'b01, 0, 0, 1, "R9");
    cyc(1, 0, 2'b01, 0, 0, 1, "R9");
    chk(count == 4 && dir == 0, "R9", count, 4);
    // R10: fixed-direction modes
    cyc(0, 1, 2'b10, 0, 0, 1, "R10");
    cyc(1, 0, 2'b10, 0, 0, 1, "R10");
    chk(count == 5 && perr == 0, "R10", count, 5);
    cyc(0, 0, 2'b11, 0, 0, 1, "R10");
    cyc(1, 1, 2'b11, 0, 0, 1, "R10");
    chk(count == 4 && dir == 0, "R10", count, 4);
    // R1: reset mid-run
    do_reset(1'b0, 1'b1);
    cyc(0, 1, 2'b00, 0, 0, 1, "R1");
    chk(count == 0, "R1", count, 0);
    // random phase
    begin
      logic [1:0] md = 2'b00;
      logic ms = 1'b0, me = 1'b1, na = 1'b0, nb = 1'b1;
      for (int i = 0; i < 3000; i++) begin
        int r;
        if (i % 200 == 0) begin
          md = 2'($urandom_range(0, 3));
          ms = 1'($urandom_range(0, 1));
          me = 1'($urandom_range(0, 1));
          if (i % 400 == 0) md = 2'b00;
        end
        r = $urandom_range(0, 99);
        if (r < 42) na = ~na;
        else if (r < 84) nb = ~nb;
        else if (r < 90) begin na = ~na; nb = ~nb; end
        cyc(na, nb, md, ms, ($urandom_range(0, 19) == 0), me, "R2");
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule